// File: doc/BRIEF.md
# Triggered Waveform Capture Buffer

This block sits behind one 8-bit ADC channel that delivers a new sample on every clock. Each sample goes into a circular history memory of 2048 entries, about 10 µs at 200 MS/s. Writing never pauses, including during a readout, so the channel has no deadtime. A trigger opens a readout window that begins a programmable number of samples before the trigger. The window is read out as a run of eight-sample frames.

Each frame passes through zero suppression before it is buffered. The frame survives only if at least one of its samples lies further from a programmable baseline than a programmable threshold. Surviving frames go into a frame FIFO that absorbs bursts. A 32-bit word stream drains the FIFO toward external memory, and the memory side can stall it with a ready signal. A trigger that arrives while a window is still being read lengthens that window. When the FIFO cannot take a frame, the frame is discarded and a sticky flag records the loss.

Top module: `trig_wave_capture`

## Requirements
- R1: One sample is stored on every clock cycle, reset excepted, whether or not a window is being read. The write position advances by one, modulo 2048, on each cycle, so every sample stays readable for 2040 cycles after it is written.
- R2: A trigger seen on a cycle whose sample timestamp is T opens a window, using the look-back value L on that cycle. The first frame of the window starts with the sample of timestamp T−L. A look-back above 2040 is treated as 2040.
- R3: A window is made of consecutive frames of 8 samples. Frame k starts at sample T−L+8k. The window holds the number of frames set on the frame-count input when the window opened, and a frame count of 0 is treated as 1.
- R4: A frame is kept only if at least one of its samples s satisfies |s − baseline| > threshold. Otherwise the frame is discarded and nothing for it appears at the output.
- R5: A kept frame leaves as three words. The first is a header: bits [31:16] hold the low 16 bits of the first sample's timestamp, [15:8] the window number (mod 256, the first window after reset being 0), and [7:0] the frame index within the window (mod 256, counting discarded frames). Then come two data words: samples 0..3 in bits [7:0], [15:8], [23:16] and [31:24] of the first, and samples 4..7 in the same positions of the second.
- R6: A trigger on any cycle in which a window is being read does not open a new window. It lengthens the current one so that it ends a set number of frames after frame k, where k is the frame being read on that cycle and the set number is the frame count then applied. That includes the window's last read cycle. The window number stays the same.
- R7: The FIFO holds 512 frames. A kept frame that finds the FIFO full is discarded and raises the overflow flag. Frames already held are delivered unchanged.
- R8: The overflow flag stays set until a cycle with the clear input high, and it reads low from the following cycle on.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold. Words leave in frame order, and within a frame in header, data, data order.
- R10: After reset, out_valid and the overflow flag are low, the FIFO is empty and the next window is numbered 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 8 | ADC sample, one per cycle |
| trig_i | input | 1 | Trigger strobe |
| lookback_i | input | 11 | Samples to reach back before the trigger |
| win_frames_i | input | 8 | Frames per window (0 acts as 1) |
| baseline_i | input | 8 | Zero-suppression reference level |
| thresh_i | input | 8 | Zero-suppression distance |
| clear_i | input | 1 | Clears the overflow flag |
| out_data_o | output | 32 | Output word |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | External memory accepts the word |
| overflow_o | output | 1 | Sticky frame-loss flag |

## Verification
A broken write pointer or read-address offset shows up in the first header and data words of the window. The timestamp and the sample bytes no longer match the known ramp that was driven in, and this is visible within about ten cycles of the trigger. A wrong suppression decision, a wrong window length or a miscounted extension changes which frames come out or how many, and this appears when the window drains. Bad FIFO pointers or lost overflow state show up only once the FIFO is full. They appear as a word count different from 512 frames, reordered words, or a flag that drops or fails to clear.

// File: rtl/twc_pkg.sv
package twc_pkg;
    localparam int SMP_W      = 8;
    localparam int FRAME_LEN  = 8;
    localparam int TS_W       = 16;
    localparam int CNT_W      = 8;
    localparam int WORD_W     = 32;
    localparam int SLOT_W     = $clog2(FRAME_LEN);
    localparam int FRAME_BITS = FRAME_LEN * SMP_W;
    localparam int WORDS      = 1 + FRAME_BITS / WORD_W;

    typedef logic [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [CNT_W-1:0] win;
        logic [CNT_W-1:0] idx;
    } hdr_t;

    typedef struct packed {
        hdr_t                  hdr;
        logic [FRAME_BITS-1:0] data;
    } frame_t;

    typedef struct packed {
        hdr_t              hdr;
        logic [SLOT_W-1:0] slot;
    } iss_t;

    function automatic logic beyond(smp_t s, smp_t base, smp_t thr);
        smp_t d;
        d = (s > base) ? smp_t'(s - base) : smp_t'(base - s);
        return d > thr;
    endfunction
endpackage

// File: rtl/twc_ring.sv
module twc_ring
    import twc_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  smp_t            sample_i,
    input  logic            rd_en_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [TS_W-1:0] ts_o,
    output smp_t            rd_data_o
);
    logic [TS_W-1:0] ts_q;
    smp_t            mem_q [DEPTH];
    smp_t            rd_q;

    always_ff @(posedge clk) begin
        if (rst) ts_q <= '0;
        else     ts_q <= ts_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        mem_q[ts_q[AW-1:0]] <= sample_i;
        if (rd_en_i) rd_q <= mem_q[rd_addr_i];
    end

    assign ts_o      = ts_q;
    assign rd_data_o = rd_q;
endmodule

// File: rtl/twc_window.sv
module twc_window
    import twc_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW     = $clog2(DEPTH),
    localparam int LB_MAX = DEPTH - FRAME_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_i,
    input  logic [AW-1:0]    lookback_i,
    input  logic [CNT_W-1:0] win_frames_i,
    input  logic [TS_W-1:0]  ts_i,
    output logic             active_o,
    output logic [AW-1:0]    rd_addr_o,
    output iss_t             iss_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    logic              active_q;
    logic [AW-1:0]     addr_q;
    logic [TS_W-1:0]   fts_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W:0]    left_q;
    logic [CNT_W-1:0]  fidx_q, wnum_q, wcnt_q;
    logic [AW-1:0]     lb_eff;
    logic [CNT_W:0]    wf;
    logic              last_slot;

    assign lb_eff    = (lookback_i > AW'(LB_MAX)) ? AW'(LB_MAX) : lookback_i;
    assign wf        = (win_frames_i == '0) ? (CNT_W+1)'(1) : {1'b0, win_frames_i};
    assign last_slot = (slot_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            fts_q    <= '0;
            slot_q   <= '0;
            left_q   <= '0;
            fidx_q   <= '0;
            wnum_q   <= '0;
            wcnt_q   <= '0;
        end else if (!active_q) begin
            if (trig_i) begin
                active_q <= 1'b1;
                addr_q   <= ts_i[AW-1:0] - lb_eff;
                fts_q    <= ts_i - TS_W'(lb_eff);
                slot_q   <= '0;
                fidx_q   <= '0;
                left_q   <= wf;
                wnum_q   <= wcnt_q;
                wcnt_q   <= wcnt_q + 1'b1;
            end
        end else begin
            addr_q <= addr_q + 1'b1;
            slot_q <= last_slot ? '0 : slot_q + 1'b1;
            if (last_slot) begin
                fidx_q <= fidx_q + 1'b1;
                fts_q  <= fts_q + TS_W'(FRAME_LEN);
            end
            if (trig_i) begin
                left_q <= last_slot ? wf : (CNT_W+1)'(wf + 1'b1);
            end else if (last_slot) begin
                left_q <= left_q - 1'b1;
                if (left_q == (CNT_W+1)'(1)) active_q <= 1'b0;
            end
        end
    end

    assign active_o      = active_q;
    assign rd_addr_o     = addr_q;
    assign iss_o.hdr.ts  = fts_q;
    assign iss_o.hdr.win = wnum_q;
    assign iss_o.hdr.idx = fidx_q;
    assign iss_o.slot    = slot_q;
endmodule

// File: rtl/twc_frame.sv
module twc_frame
    import twc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   valid_i,
    input  iss_t   iss_i,
    input  smp_t   smp_i,
    input  smp_t   baseline_i,
    input  smp_t   thresh_i,
    output logic   done_o,
    output logic   keep_o,
    output frame_t frame_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME_LEN - 1);

    smp_t buf_q [FRAME_LEN];
    logic hit_q;
    logic hit_now;

    assign hit_now = beyond(smp_i, baseline_i, thresh_i);

    always_ff @(posedge clk) begin
        if (valid_i) buf_q[iss_i.slot] <= smp_i;
    end

    always_ff @(posedge clk) begin
        if (rst)          hit_q <= 1'b0;
        else if (valid_i) hit_q <= (iss_i.slot == '0) ? hit_now : (hit_q | hit_now);
    end

    assign done_o      = valid_i && (iss_i.slot == LAST);
    assign keep_o      = hit_q | hit_now;
    assign frame_o.hdr = iss_i.hdr;

    for (genvar g = 0; g < FRAME_LEN - 1; g++) begin : g_pack
        assign frame_o.data[g*SMP_W +: SMP_W] = buf_q[g];
    end
    assign frame_o.data[(FRAME_LEN-1)*SMP_W +: SMP_W] = smp_i;
endmodule

// File: rtl/twc_fifo.sv
module twc_fifo
    import twc_pkg::*;
#(
    parameter int FRAMES = 512,
    localparam int PW = $clog2(FRAMES),
    localparam int SW = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  frame_t            frame_i,
    input  logic              clear_i,
    input  logic              out_ready_i,
    output logic [WORD_W-1:0] out_data_o,
    output logic              out_valid_o,
    output logic              overflow_o,
    output logic              drop_o
);
    frame_t         store_q [FRAMES];
    logic [PW:0]    wr_q, rd_q;
    logic [SW-1:0]  sel_q;
    logic           full, empty, pop, ovf_q;
    frame_t         head;
    logic [WORD_W-1:0] words [WORDS];

    assign full   = (wr_q - rd_q) == (PW+1)'(FRAMES);
    assign empty  = (wr_q == rd_q);
    assign drop_o = push_i && full;
    assign head   = store_q[rd_q[PW-1:0]];
    assign pop    = !empty && out_ready_i && (sel_q == SW'(WORDS - 1));

    assign words[0] = head.hdr;
    for (genvar g = 1; g < WORDS; g++) begin : g_words
        assign words[g] = head.data[(g-1)*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (push_i && !full) store_q[wr_q[PW-1:0]] <= frame_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            sel_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (push_i && !full) wr_q <= wr_q + 1'b1;
            if (!empty && out_ready_i) begin
                sel_q <= pop ? '0 : sel_q + 1'b1;
                if (pop) rd_q <= rd_q + 1'b1;
            end
            if (drop_o)       ovf_q <= 1'b1;
            else if (clear_i) ovf_q <= 1'b0;
        end
    end

    assign out_valid_o = !empty;
    assign out_data_o  = words[sel_q];
    assign overflow_o  = ovf_q;
endmodule

// File: rtl/trig_wave_capture.sv
module trig_wave_capture
    import twc_pkg::*;
#(
    parameter int DEPTH  = 2048,
    parameter int FRAMES = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic              trig_i,
    input  logic [AW-1:0]     lookback_i,
    input  logic [CNT_W-1:0]  win_frames_i,
    input  logic [SMP_W-1:0]  baseline_i,
    input  logic [SMP_W-1:0]  thresh_i,
    input  logic              clear_i,
    output logic [WORD_W-1:0] out_data_o,
    output logic              out_valid_o,
    input  logic              out_ready_i,
    output logic              overflow_o
);
    logic [TS_W-1:0] ts_w;
    logic            active_w;
    logic [AW-1:0]   rd_addr_w;
    iss_t            iss_w, s1_iss_q;
    logic            s1_valid_q;
    smp_t            rd_data_w;
    logic            done_w, keep_w, drop_w;
    frame_t          frame_w;

    twc_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .sample_i(sample_i),
        .rd_en_i(active_w), .rd_addr_i(rd_addr_w),
        .ts_o(ts_w), .rd_data_o(rd_data_w)
    );

    twc_window #(.DEPTH(DEPTH)) u_window (
        .clk(clk), .rst(rst), .trig_i(trig_i),
        .lookback_i(lookback_i), .win_frames_i(win_frames_i), .ts_i(ts_w),
        .active_o(active_w), .rd_addr_o(rd_addr_w), .iss_o(iss_w)
    );

    always_ff @(posedge clk) begin
        if (rst) s1_valid_q <= 1'b0;
        else     s1_valid_q <= active_w;
    end

    always_ff @(posedge clk) begin
        s1_iss_q <= iss_w;
    end

    twc_frame u_frame (
        .clk(clk), .rst(rst), .valid_i(s1_valid_q), .iss_i(s1_iss_q),
        .smp_i(rd_data_w), .baseline_i(baseline_i), .thresh_i(thresh_i),
        .done_o(done_w), .keep_o(keep_w), .frame_o(frame_w)
    );

    twc_fifo #(.FRAMES(FRAMES)) u_fifo (
        .clk(clk), .rst(rst), .push_i(done_w && keep_w), .frame_i(frame_w),
        .clear_i(clear_i), .out_ready_i(out_ready_i),
        .out_data_o(out_data_o), .out_valid_o(out_valid_o),
        .overflow_o(overflow_o), .drop_o(drop_w)
    );
endmodule

// File: rtl/trig_wave_capture_chk.sv
module trig_wave_capture_chk #(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst,
    input logic          trig,
    input logic          active,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rd_addr,
    input logic [31:0]   out_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic          overflow,
    input logic          clear,
    input logic          drop
);
    p_write_advance_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wp == $past(wp) + 1'b1);

    p_reader_apart_r1: assert property (@(posedge clk) disable iff (rst)
        active |-> rd_addr != wp);

    p_extend_r6: assert property (@(posedge clk) disable iff (rst)
        active && trig |=> active);

    p_drop_flags_r7: assert property (@(posedge clk) disable iff (rst)
        drop |=> overflow);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        overflow && !clear |=> overflow);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clear && !drop |=> !overflow);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

bind trig_wave_capture trig_wave_capture_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .trig(trig_i), .active(active_w),
    .wp(ts_w[AW-1:0]), .rd_addr(rd_addr_w),
    .out_data(out_data_o), .out_valid(out_valid_o), .out_ready(out_ready_i),
    .overflow(overflow_o), .clear(clear_i), .drop(drop_w)
);

// File: tb/trig_wave_capture_tb.sv
module trig_wave_capture_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LB_CAP     = 2040;
    localparam int NROWS      = 6;
    localparam int V_LB  [NROWS] = '{16, 0, 2047, 300, 40, 1000};
    localparam int V_WIN [NROWS] = '{6, 3, 2, 0, 5, 10};
    localparam int V_BASE[NROWS] = '{100, 100, 100, 0, 100, 130};
    localparam int V_THR [NROWS] = '{2, 2, 0, 0, 255, 12};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [10:0] lookback = '0;
    logic [7:0]  win_frames = 8'd1;
    logic [7:0]  baseline = '0;
    logic [7:0]  thresh = '0;
    logic        clear = 1'b0;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        out_valid;
    logic        overflow;
    logic [7:0]  sample;
    int          bts;
    int          checks = 0;
    int          errs = 0;
    logic [31:0] got [$];
    logic [31:0] expw [$];

    function automatic logic [7:0] fpat(int t);
        int m;
        m = t % 37;
        if (m < 5) return 8'(120 + 3 * m);
        return 8'(99 + (t % 3));
    endfunction

    always @(posedge clk) begin
        if (rst) bts <= 0;
        else     bts <= bts + 1;
    end
    assign sample = fpat(bts);

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    trig_wave_capture dut_i (
        .clk(clk), .rst(rst), .sample_i(sample), .trig_i(trig),
        .lookback_i(lookback), .win_frames_i(win_frames),
        .baseline_i(baseline), .thresh_i(thresh), .clear_i(clear),
        .out_data_o(out_data), .out_valid_o(out_valid),
        .out_ready_i(out_ready), .overflow_o(overflow)
    );

    initial forever begin
        @(negedge clk);
        #1;
        if (!rst && out_valid && out_ready) got.push_back(out_data);
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic model(input int t0, input int lbraw, input int nfr, input int wn,
                         input int base, input int thr, input int maxf);
        int lc;
        int kept;
        lc = (lbraw > LB_CAP) ? LB_CAP : lbraw;
        kept = 0;
        for (int k = 0; k < nfr; k++) begin
            int s;
            logic hit;
            logic [31:0] w1, w2;
            s = t0 - lc + 8 * k;
            hit = 1'b0;
            for (int j = 0; j < 8; j++) begin
                int v, d;
                v = int'(fpat(s + j));
                d = (v > base) ? v - base : base - v;
                if (d > thr) hit = 1'b1;
                if (j < 4) w1[8*j +: 8] = 8'(v);
                else       w2[8*(j-4) +: 8] = 8'(v);
            end
            if (hit) begin
                if (kept < maxf) begin
                    expw.push_back({16'(s), 8'(wn), 8'(k)});
                    expw.push_back(w1);
                    expw.push_back(w2);
                end
                kept++;
            end
        end
    endtask

    task automatic compare(input string req);
        int n;
        check(got.size() == expw.size(), req, 32'(got.size()), 32'(expw.size()));
        n = (got.size() < expw.size()) ? got.size() : expw.size();
        for (int i = 0; i < n; i++) check(got[i] === expw[i], req, got[i], expw[i]);
        got.delete();
        expw.delete();
    endtask

    task automatic trig_at(input int t);
        while (bts < t) @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        int t0;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: clean state after reset
        check(out_valid == 1'b0, "R10 valid after reset", 32'(out_valid), 0);
        check(overflow == 1'b0, "R10 overflow after reset", 32'(overflow), 0);

        // R1 history fill before any look-back reaches it
        while (bts < 2100) @(negedge clk);

        // Table: R2 R3 R4 R5 R9 (window numbers 0..5 also cover R10)
        for (int r = 0; r < NROWS; r++) begin
            int nf;
            lookback   = 11'(V_LB[r]);
            win_frames = 8'(V_WIN[r]);
            baseline   = 8'(V_BASE[r]);
            thresh     = 8'(V_THR[r]);
            @(negedge clk);
            t0 = bts;
            trig_at(t0);
            nf = (V_WIN[r] == 0) ? 1 : V_WIN[r];
            repeat (nf * 8 + 60) @(negedge clk);
            model(t0, V_LB[r], nf, r, V_BASE[r], V_THR[r], 1 << 30);
            compare($sformatf("R2 R3 R4 R5 row %0d", r));
        end

        // R6: extension mid-frame and on the last read cycle, window 6
        lookback = 11'd8; win_frames = 8'd4; baseline = 8'd0; thresh = 8'd0;
        @(negedge clk);
        t0 = bts;
        trig_at(t0);
        trig_at(t0 + 1 + 8 * 2 + 3);
        trig_at(t0 + 1 + 8 * 6 + 7);
        repeat (11 * 8 + 80) @(negedge clk);
        model(t0, 8, 11, 6, 0, 0, 1 << 30);
        compare("R6 extension");

        // R7 R8 R9: fill past 512 frames with the drain stalled, window 7
        out_ready = 1'b0;
        lookback = 11'd0; win_frames = 8'd255;
        @(negedge clk);
        t0 = bts;
        trig_at(t0);
        trig_at(t0 + 1 + 8 * 200);
        trig_at(t0 + 1 + 8 * 400 + 5);
        while (bts < t0 + 656 * 8 + 40) @(negedge clk);
        check(overflow == 1'b1, "R7 overflow set", 32'(overflow), 1);
        held = out_data;
        repeat (10) @(negedge clk);
        check(overflow == 1'b1, "R8 overflow sticky", 32'(overflow), 1);
        check(out_valid == 1'b1, "R9 valid held", 32'(out_valid), 1);
        check(out_data == held, "R9 data held", out_data, held);
        out_ready = 1'b1;
        repeat (1600) @(negedge clk);
        model(t0, 0, 656, 7, 0, 0, 512);
        compare("R7 stored frames intact");
        check(overflow == 1'b1, "R8 overflow after drain", 32'(overflow), 1);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        check(overflow == 1'b0, "R8 overflow cleared", 32'(overflow), 0);

        // R10: reset with data pending
        out_ready = 1'b0;
        win_frames = 8'd2;
        @(negedge clk);
        trig_at(bts);
        repeat (40) @(negedge clk);
        check(out_valid == 1'b1, "R9 pending data visible", 32'(out_valid), 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R10 valid cleared by reset", 32'(out_valid), 0);
        check(overflow == 1'b0, "R10 overflow cleared by reset", 32'(overflow), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule